// File: doc/BRIEF.md
# NAND Page Array with Bit-Clearing Program

A small on-chip NAND-style storage array that sits behind a command sequencer. It holds a number of pages. Each row is a main area followed by a spare area one thirty-second its size. Pages are grouped into erase blocks of 2^ERASE_SHIFT pages. A single page buffer sits between the array and the client. The client fills the buffer byte by byte, or reads it at any index. One request at a time asks the array to do one of three things:

- copy a page into the buffer, starting from a column offset;
- fold the buffer contents into a page, starting from a column offset;
- erase the whole aligned block that contains a page.

Programming behaves like real flash: each buffered byte is ANDed into the byte already stored, so a program can only clear bits. Only an erase sets bits back to one. After reset the block sweeps the whole array to 0xFF before it accepts work. Every accepted request holds `busy` high and then pulses `done` for one cycle. A rejected or out-of-range request also raises `done_err` in that same cycle.

Top module: `nand_page_array`

## Requirements
- R1: From reset, `busy` stays high for exactly TOTAL cycles after reset is released, where TOTAL = pages x row bytes. During that time every array byte is written to 0xFF. No `done` pulse follows this sweep.
- R2: Opcode 2'b00 (load) with a page below the page count and a column `col` no larger than the row size (main + main/32, 66 bytes by default) copies array byte `col+i` of that page into buffer index `i`. It sets `buf_len` to row size minus `col`, so `col` equal to the row size yields an empty buffer.
- R3: A load whose column exceeds the row size, or whose page is at or beyond the page count, finishes with `done_err`=1 and leaves `buf_len`=0.
- R4: While idle, each cycle with `buf_wr_en` high appends `buf_wr_data` at index `buf_len` and increments `buf_len`. A write is ignored when `buf_len` already equals the row size, or while `busy` is high.
- R5: Opcode 2'b01 (program) ANDs buffer byte `i` into array byte `col+i` of the page, for `i` below the smaller of `buf_len` and row size minus `col`. Every other byte keeps its value, and `buf_len` is 0 once the request completes.
- R6: A program aimed at a page at or beyond the page count changes no array byte. It finishes with `done_err`=1 and still empties the buffer.
- R7: Opcode 2'b10 (erase) clears the low ERASE_SHIFT bits of the page number to find the block base. It then sets every byte, spare included, of the 2^ERASE_SHIFT pages from that base to 0xFF, and leaves all other blocks untouched.
- R8: An erase aimed at a page at or beyond the page count changes nothing and finishes with `done_err`=1.
- R9: Opcode 2'b11 is reserved. It changes nothing and finishes with `done_err`=1.
- R10: An accepted request holds `busy` high for 2n+1 cycles for a load or program moving n bytes, for block-bytes+1 cycles for an erase, and for 1 cycle when it is rejected. `done` is high for exactly the one cycle after `busy` falls, with `done_err` valid in that cycle.
- R11: A request presented while `busy` is high is ignored and alters neither timing nor data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 00 load, 01 program, 10 erase, 11 reserved |
| req_page | input | PAGE_W (5) | Page number, one bit wider than needed so out-of-range pages can be expressed |
| req_col | input | COL_W (8) | Column offset within the row |
| busy | output | 1 | Request or reset sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request was rejected; valid with `done` |
| buf_wr_en | input | 1 | Append one byte to the page buffer |
| buf_wr_data | input | 8 | Byte to append |
| buf_rd_idx | input | IDX_W (7) | Buffer index to read |
| buf_rd_data | output | 8 | Buffer byte at `buf_rd_idx`, 0 beyond the row |
| buf_len | output | COL_W (8) | Number of valid bytes in the buffer |

## Verification
The assertions assume that the client never presents a request and a buffer write in the same idle cycle. The bench honours this by always separating the two by at least one clock. They also assume `req_page` and `req_col` are only meaningful in the cycle `req_valid` is high. The stimulus changes them only on falling edges together with the strobe. Requests during `busy` are sent on purpose to exercise R11, and buffer writes during `busy` are sent to exercise R4.

// File: rtl/nand_pa_pkg.sv
package nand_pa_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_LD_RD = 3'd2,
        ST_LD_WR = 3'd3,
        ST_PG_RD = 3'd4,
        ST_PG_WR = 3'd5,
        ST_ERASE = 3'd6,
        ST_FIN   = 3'd7
    } st_e;

endpackage

// File: rtl/nand_pa_store.sv
module nand_pa_store #(
    parameter int DEPTH = 1056,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

    logic [7:0] cells_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[addr_i] <= wdata_i;
        end
        rdata_q <= cells_q[addr_i];
    end

    assign rdata_o = rdata_q;

    // R7
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> ({1'b0, addr_i} < DEPTH_C));

endmodule

// File: rtl/nand_pa_pagebuf.sv
module nand_pa_pagebuf #(
    parameter int ROW_BYTES = 66,
    parameter int IDX_W     = 7,
    parameter int COL_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             host_we_i,
    input  logic [7:0]       host_data_i,
    input  logic [IDX_W-1:0] host_rd_idx_i,
    output logic [7:0]       host_rd_data_o,
    input  logic             seq_clear_i,
    input  logic             seq_we_i,
    input  logic [IDX_W-1:0] seq_idx_i,
    input  logic [7:0]       seq_data_i,
    input  logic [IDX_W-1:0] seq_rd_idx_i,
    output logic [7:0]       seq_rd_data_o,
    output logic [COL_W-1:0] len_o
);
    localparam logic [COL_W-1:0] ROW_C = COL_W'(ROW_BYTES);

    typedef struct packed {
        logic [ROW_BYTES-1:0][7:0] bytes;
        logic [COL_W-1:0]          len;
    } pb_t;

    pb_t pb_q, pb_d;
    logic [IDX_W-1:0] app_pos;

    assign app_pos = pb_q.len[IDX_W-1:0];

    always_comb begin
        pb_d = pb_q;
        if (seq_clear_i) begin
            pb_d.len = '0;
        end else if (seq_we_i) begin
            pb_d.bytes[seq_idx_i] = seq_data_i;
            pb_d.len = COL_W'(seq_idx_i) + COL_W'(1);
        end else if (host_we_i && !busy_i && (pb_q.len < ROW_C)) begin
            pb_d.bytes[app_pos] = host_data_i;
            pb_d.len = pb_q.len + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q <= '0;
        end else begin
            pb_q <= pb_d;
        end
    end

    assign host_rd_data_o = ({1'b0, host_rd_idx_i} < ROW_C) ? pb_q.bytes[host_rd_idx_i] : 8'h00;
    assign seq_rd_data_o  = pb_q.bytes[seq_rd_idx_i];
    assign len_o          = pb_q.len;

    // R4
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_q.len <= ROW_C);

    // R4
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && host_we_i && !seq_we_i && !seq_clear_i) |=> $stable(pb_q.len));

endmodule

// File: rtl/nand_pa_seq.sv
module nand_pa_seq
    import nand_pa_pkg::*;
#(
    parameter int ROW_BYTES   = 66,
    parameter int NUM_PAGES   = 16,
    parameter int ERASE_SHIFT = 2,
    parameter int TOTAL       = 1056,
    parameter int AW          = 11,
    parameter int IDX_W       = 7,
    parameter int COL_W       = 8,
    parameter int PAGE_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [PAGE_W-1:0] req_page_i,
    input  logic [COL_W-1:0]  req_col_i,
    input  logic [COL_W-1:0]  buf_len_i,
    input  logic [7:0]        buf_rd_data_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              done_err_o,
    output logic              buf_clear_o,
    output logic              buf_we_o,
    output logic [IDX_W-1:0]  buf_idx_o,
    output logic [7:0]        buf_wdata_o,
    output logic [IDX_W-1:0]  buf_rd_idx_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              prog_wr_o
);
    localparam int               LEFT_W      = AW + 1;
    localparam int               BLOCK_BYTES = ROW_BYTES << ERASE_SHIFT;
    localparam logic [COL_W-1:0]  ROW_C      = COL_W'(ROW_BYTES);
    localparam logic [PAGE_W-1:0] NP_C       = PAGE_W'(NUM_PAGES);
    localparam logic [PAGE_W-1:0] BLK_MASK   = ~PAGE_W'((1 << ERASE_SHIFT) - 1);
    localparam logic [AW-1:0]     ROW_A      = AW'(ROW_BYTES);
    localparam logic [LEFT_W-1:0] TOTAL_L    = LEFT_W'(TOTAL);
    localparam logic [LEFT_W-1:0] BLOCK_L    = LEFT_W'(BLOCK_BYTES);
    localparam logic [LEFT_W-1:0] ONE_L      = LEFT_W'(1);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic              err;
        logic              done;
        logic [AW-1:0]     addr;
        logic [IDX_W-1:0]  idx;
        logic [LEFT_W-1:0] left;
    } seq_t;

    seq_t sq_q, sq_d;

    logic              page_ok, col_ok, last_byte;
    logic [COL_W-1:0]  room, pg_n;
    logic [PAGE_W-1:0] blk_page;
    logic [AW-1:0]     row_base, col_addr, blk_base;

    always_comb begin
        page_ok   = req_page_i < NP_C;
        col_ok    = req_col_i <= ROW_C;
        room      = ROW_C - req_col_i;
        pg_n      = (req_col_i < ROW_C) ? ((buf_len_i < room) ? buf_len_i : room) : '0;
        row_base  = AW'(req_page_i) * ROW_A;
        col_addr  = row_base + AW'(req_col_i);
        blk_page  = req_page_i & BLK_MASK;
        blk_base  = AW'(blk_page) * ROW_A;
        last_byte = sq_q.left == ONE_L;
    end

    always_comb begin
        sq_d        = sq_q;
        sq_d.done   = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = 8'hFF;
        buf_we_o    = 1'b0;
        buf_clear_o = 1'b0;
        prog_wr_o   = 1'b0;
        case (sq_q.st)
            ST_INIT: begin
                mem_we_o  = 1'b1;
                sq_d.addr = sq_q.addr + AW'(1);
                sq_d.left = sq_q.left - ONE_L;
                if (last_byte) sq_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid_i) begin
                    sq_d.op  = op_e'(req_op_i);
                    sq_d.err = 1'b0;
                    sq_d.idx = '0;
                    sq_d.st  = ST_FIN;
                    case (op_e'(req_op_i))
                        OP_LOAD: begin
                            buf_clear_o = 1'b1;
                            if (page_ok && col_ok) begin
                                sq_d.addr = col_addr;
                                sq_d.left = LEFT_W'(room);
                                if (room != '0) sq_d.st = ST_LD_RD;
                            end else begin
                                sq_d.err = 1'b1;
                            end
                        end
                        OP_PROG: begin
                            if (page_ok) begin
                                sq_d.addr = col_addr;
                                sq_d.left = LEFT_W'(pg_n);
                                if (pg_n != '0) sq_d.st = ST_PG_RD;
                            end else begin
                                sq_d.err = 1'b1;
                            end
                        end
                        OP_ERASE: begin
                            if (page_ok) begin
                                sq_d.addr = blk_base;
                                sq_d.left = BLOCK_L;
                                sq_d.st   = ST_ERASE;
                            end else begin
                                sq_d.err = 1'b1;
                            end
                        end
                        default: sq_d.err = 1'b1;
                    endcase
                end
            end
            ST_LD_RD: sq_d.st = ST_LD_WR;
            ST_LD_WR: begin
                buf_we_o  = 1'b1;
                sq_d.addr = sq_q.addr + AW'(1);
                sq_d.idx  = sq_q.idx + IDX_W'(1);
                sq_d.left = sq_q.left - ONE_L;
                sq_d.st   = last_byte ? ST_FIN : ST_LD_RD;
            end
            ST_PG_RD: sq_d.st = ST_PG_WR;
            ST_PG_WR: begin
                mem_we_o    = 1'b1;
                prog_wr_o   = 1'b1;
                mem_wdata_o = mem_rdata_i & buf_rd_data_i;
                sq_d.addr   = sq_q.addr + AW'(1);
                sq_d.idx    = sq_q.idx + IDX_W'(1);
                sq_d.left   = sq_q.left - ONE_L;
                sq_d.st     = last_byte ? ST_FIN : ST_PG_RD;
            end
            ST_ERASE: begin
                mem_we_o  = 1'b1;
                sq_d.addr = sq_q.addr + AW'(1);
                sq_d.left = sq_q.left - ONE_L;
                if (last_byte) sq_d.st = ST_FIN;
            end
            ST_FIN: begin
                sq_d.st   = ST_IDLE;
                sq_d.done = 1'b1;
                if (sq_q.op == OP_PROG) buf_clear_o = 1'b1;
            end
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: ST_INIT, op: OP_LOAD, err: 1'b0, done: 1'b0,
                      addr: '0, idx: '0, left: TOTAL_L};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o       = sq_q.st != ST_IDLE;
    assign done_o       = sq_q.done;
    assign done_err_o   = sq_q.done & sq_q.err;
    assign buf_idx_o    = sq_q.idx;
    assign buf_wdata_o  = mem_rdata_i;
    assign buf_rd_idx_o = sq_q.idx;
    assign mem_addr_o   = sq_q.addr;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    // R11
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_valid_i) |=> $stable(sq_q.op));

endmodule

// File: rtl/nand_page_array.sv
module nand_page_array #(
    parameter int PAGE_BYTES  = 64,
    parameter int ERASE_SHIFT = 2,
    parameter int NUM_BLOCKS  = 4,
    localparam int SPARE_BYTES = PAGE_BYTES / 32,
    localparam int ROW_BYTES   = PAGE_BYTES + SPARE_BYTES,
    localparam int NUM_PAGES   = NUM_BLOCKS << ERASE_SHIFT,
    localparam int TOTAL       = NUM_PAGES * ROW_BYTES,
    localparam int AW          = $clog2(TOTAL),
    localparam int IDX_W       = $clog2(ROW_BYTES),
    localparam int COL_W       = IDX_W + 1,
    localparam int PAGE_W      = $clog2(NUM_PAGES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [COL_W-1:0]  req_col,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    input  logic              buf_wr_en,
    input  logic [7:0]        buf_wr_data,
    input  logic [IDX_W-1:0]  buf_rd_idx,
    output logic [7:0]        buf_rd_data,
    output logic [COL_W-1:0]  buf_len
);
    logic             buf_clear, buf_we, mem_we, prog_wr;
    logic [IDX_W-1:0] buf_idx, seq_rd_idx;
    logic [7:0]       buf_wdata, seq_rd_data, mem_rdata, mem_wdata;
    logic [AW-1:0]    mem_addr;

    nand_pa_seq #(
        .ROW_BYTES(ROW_BYTES), .NUM_PAGES(NUM_PAGES), .ERASE_SHIFT(ERASE_SHIFT),
        .TOTAL(TOTAL), .AW(AW), .IDX_W(IDX_W), .COL_W(COL_W), .PAGE_W(PAGE_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_page_i(req_page), .req_col_i(req_col),
        .buf_len_i(buf_len), .buf_rd_data_i(seq_rd_data), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .done_err_o(done_err),
        .buf_clear_o(buf_clear), .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_wdata_o(buf_wdata),
        .buf_rd_idx_o(seq_rd_idx), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .prog_wr_o(prog_wr)
    );

    nand_pa_pagebuf #(
        .ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W), .COL_W(COL_W)
    ) pagebuf_i (
        .clk(clk), .rst_n(rst_n), .busy_i(busy),
        .host_we_i(buf_wr_en), .host_data_i(buf_wr_data),
        .host_rd_idx_i(buf_rd_idx), .host_rd_data_o(buf_rd_data),
        .seq_clear_i(buf_clear), .seq_we_i(buf_we), .seq_idx_i(buf_idx), .seq_data_i(buf_wdata),
        .seq_rd_idx_i(seq_rd_idx), .seq_rd_data_o(seq_rd_data), .len_o(buf_len)
    );

    nand_pa_store #(
        .DEPTH(TOTAL), .AW(AW)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .we_i(mem_we), .addr_i(mem_addr),
        .wdata_i(mem_wdata), .rdata_o(mem_rdata)
    );

    // R5
    prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_wr |-> ((mem_wdata & ~mem_rdata) == 8'h00));

endmodule

// File: tb/nand_page_array_tb.sv
module nand_page_array_tb_top;
    localparam int CLK_P = 10;
    localparam int ROW   = 66;
    localparam int PPB   = 4;
    localparam int NP    = 16;
    localparam int TOTAL = NP * ROW;
    localparam int BLK   = PPB * ROW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [4:0] req_page = '0;
    logic [7:0] req_col = '0;
    logic       busy, done, done_err;
    logic       buf_wr_en = 1'b0;
    logic [7:0] buf_wr_data = '0;
    logic [6:0] buf_rd_idx = '0;
    logic [7:0] buf_rd_data;
    logic [7:0] buf_len;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit last_err = 0;

    always #(CLK_P/2) clk = ~clk;

    nand_page_array dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_page(req_page), .req_col(req_col), .busy(busy), .done(done),
        .done_err(done_err), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
        .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data), .buf_len(buf_len)
    );

    // reference model
    logic [7:0] mmem [TOTAL];
    logic [7:0] mbuf [ROW];
    int  mlen = 0;
    int  m_left = TOTAL;
    bit  m_done = 0;
    bit  m_err = 0;
    bit  m_init = 1;

    function automatic void m_accept(int op, int pg, int col);
        int n;
        int base;
        bit pg_ok;
        pg_ok = pg < NP;
        m_err = 0;
        case (op)
            0: begin
                if (pg_ok && col <= ROW) begin
                    n = ROW - col;
                    for (int i = 0; i < n; i++) mbuf[i] = mmem[pg*ROW + col + i];
                    mlen = n;
                    m_left = 2*n + 1;
                end else begin
                    mlen = 0; m_left = 1; m_err = 1;
                end
            end
            1: begin
                if (pg_ok) begin
                    n = (col < ROW) ? ((mlen < ROW - col) ? mlen : ROW - col) : 0;
                    for (int i = 0; i < n; i++)
                        mmem[pg*ROW + col + i] = mmem[pg*ROW + col + i] & mbuf[i];
                    m_left = 2*n + 1;
                end else begin
                    m_left = 1; m_err = 1;
                end
                mlen = 0;
            end
            2: begin
                if (pg_ok) begin
                    base = (pg / PPB) * PPB * ROW;
                    for (int i = 0; i < BLK; i++) mmem[base + i] = 8'hFF;
                    m_left = BLK + 1;
                end else begin
                    m_left = 1; m_err = 1;
                end
            end
            default: begin
                m_left = 1; m_err = 1;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = TOTAL; m_done = 0; m_init = 1; mlen = 0;
            for (int i = 0; i < TOTAL; i++) mmem[i] = 8'hFF;
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_done = !m_init;
                    m_init = 0;
                end
            end else if (req_valid) begin
                m_accept(int'(req_op), int'(req_page), int'(req_col));
            end else if (buf_wr_en && mlen < ROW) begin
                mbuf[mlen] = buf_wr_data;
                mlen++;
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of handshake outputs against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == (m_left > 0), "R10 busy timing", int'(busy), int'(m_left > 0));
            check(done == m_done, "R10 done pulse", int'(done), int'(m_done));
            if (m_done) check(done_err == m_err, "R10 done_err", int'(done_err), int'(m_err));
        end
    end

    task automatic issue(int op, int pg, int col);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_page  = 5'(pg);
        req_col   = 8'(col);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk);
            if (done) last_err = done_err;
        end while (m_left != 0 || m_done);
    endtask

    task automatic push(int n, int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_wr_en   = 1'b1;
            buf_wr_data = 8'((seed + i * 37) ^ (i << 3));
        end
        @(negedge clk);
        buf_wr_en = 1'b0;
    endtask

    task automatic push_byte(logic [7:0] b);
        @(negedge clk);
        buf_wr_en   = 1'b1;
        buf_wr_data = b;
        @(negedge clk);
        buf_wr_en = 1'b0;
    endtask

    task automatic check_buf(string tag);
        check(int'(buf_len) == mlen, {tag, " buf_len"}, int'(buf_len), mlen);
        for (int i = 0; i < mlen; i++) begin
            buf_rd_idx = 7'(i);
            #1;
            check(buf_rd_data == mbuf[i], {tag, " buf data"}, int'(buf_rd_data), int'(mbuf[i]));
        end
    endtask

    task automatic byte_at(int i, output logic [7:0] b);
        buf_rd_idx = 7'(i);
        #1;
        b = buf_rd_data;
    endtask

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
        rst_n = 1'b1;
        wait_idle();
        check(busy == 1'b0, "R1 idle after sweep", int'(busy), 0);

        // R1 / R2: erased page 0 loads as all ones, full row length
        issue(0, 0, 0); wait_idle();
        check(int'(buf_len) == ROW, "R2 row length", int'(buf_len), ROW);
        for (int i = 0; i < ROW; i++) begin
            byte_at(i, b);
            check(b == 8'hFF, "R1 erased byte", int'(b), 8'hFF);
        end
        issue(0, NP-1, 10); wait_idle(); check_buf("R2 last page offset");

        // R4 append and R5 program
        issue(0, 0, ROW); wait_idle();
        check(int'(buf_len) == 0, "R2 empty at row end", int'(buf_len), 0);
        push_byte(8'h0F); push_byte(8'h3C); push_byte(8'hA5); push_byte(8'hFF);
        check(int'(buf_len) == 4, "R4 append count", int'(buf_len), 4);
        issue(1, 3, 5); wait_idle();
        check(int'(buf_len) == 0, "R5 buffer emptied", int'(buf_len), 0);
        issue(0, 3, 4); wait_idle(); check_buf("R5 program page 3");
        byte_at(0, b); check(b == 8'hFF, "R5 byte before untouched", int'(b), 8'hFF);
        byte_at(1, b); check(b == 8'h0F, "R5 programmed byte", int'(b), 8'h0F);
        byte_at(5, b); check(b == 8'hFF, "R5 byte after untouched", int'(b), 8'hFF);

        // R5 AND semantics
        issue(0, 0, ROW); wait_idle();
        push_byte(8'hF3);
        issue(1, 3, 5); wait_idle();
        issue(0, 3, 5); wait_idle();
        byte_at(0, b); check(b == 8'h03, "R5 AND into stored", int'(b), 8'h03);

        // R5 clipping at the end of the spare area
        push(10, 17);
        issue(1, 8, 60); wait_idle();
        issue(0, 8, 58); wait_idle(); check_buf("R5 clipped into spare");

        // R4 overfill
        issue(0, 0, ROW); wait_idle();
        push(70, 91);
        check(int'(buf_len) == ROW, "R4 full buffer", int'(buf_len), ROW);
        issue(1, 9, 0); wait_idle();
        issue(0, 9, 0); wait_idle(); check_buf("R5 full row program");

        // R3 rejected loads
        issue(0, 2, ROW + 1); wait_idle();
        check(last_err == 1'b1, "R3 column too large", int'(last_err), 1);
        check(int'(buf_len) == 0, "R3 buffer empty", int'(buf_len), 0);
        issue(0, NP, 0); wait_idle();
        check(last_err == 1'b1, "R3 page out of range", int'(last_err), 1);

        // R6 program out of range
        push(2, 5);
        issue(1, 20, 0); wait_idle();
        check(last_err == 1'b1, "R6 program rejected", int'(last_err), 1);
        check(int'(buf_len) == 0, "R6 buffer emptied", int'(buf_len), 0);

        // R8 / R9
        issue(2, 17, 0); wait_idle();
        check(last_err == 1'b1, "R8 erase rejected", int'(last_err), 1);
        issue(3, 1, 0); wait_idle();
        check(last_err == 1'b1, "R9 reserved op", int'(last_err), 1);
        issue(0, 8, 58); wait_idle(); check_buf("R8 R9 data unchanged");

        // prepare block 1 content, then R7 erase with R11 and R4 busy stimulus
        issue(0, 0, ROW); wait_idle();
        push(20, 200);
        issue(1, 6, 30); wait_idle();
        issue(0, 6, 0); wait_idle(); check_buf("R5 page 6 programmed");
        issue(0, 0, ROW); wait_idle();
        issue(2, 5, 0);
        push(3, 7);
        issue(0, 8, 0);
        wait_idle();
        check(last_err == 1'b0, "R7 erase ok", int'(last_err), 0);
        check(int'(buf_len) == 0, "R11 R4 busy stimulus ignored", int'(buf_len), 0);
        issue(0, 6, 0); wait_idle();
        for (int i = 0; i < ROW; i++) begin
            byte_at(i, b);
            check(b == 8'hFF, "R7 block erased", int'(b), 8'hFF);
        end
        issue(0, 8, 58); wait_idle(); check_buf("R7 next block kept");
        issue(0, 3, 0); wait_idle(); check_buf("R7 previous block kept");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule